// File: doc/BRIEF.md
# Burst Bus Target Interface

This block is the target end of a synchronous burst bus whose address and data share one set of lines. An initiator opens a transaction by pulling an active-low cycle signal low while it drives a command and a byte address. If the command is known and the address falls inside the target's window, the target claims the transaction. It then moves one word per clock edge on which both sides signal ready, and it steps through a small local memory port.

Either side can pause the burst by withholding its ready signal. The initiator marks the final beat by releasing the cycle signal on that beat. The target disconnects by asserting a halt signal when the word it is serving is the last one in its window. A programmable number of wait states holds off the very first beat of each transaction.

Top module: `burst_tgt`

## Requirements
- R1: While reset is held, and in the first cycle after it, `claim_n`, `tgt_rdy_n` and `tgt_halt_n` are high and `ad_oe` and `loc_wr` are low.
- R2: On a rising edge in the idle phase with `cyc_n` low, the block samples `cmd` and `ad_in`. Command 4'h6 is a read and 4'h7 is a write. The word address `ad_in[31:2]` hits when it lies in [BASE/4, BASE/4+DEPTH). On a hit with a known command, `claim_n` goes low from the next cycle until the final beat.
- R3: A word moves only on a rising edge where both `ini_rdy_n` and `tgt_rdy_n` are low. A high `ini_rdy_n` stalls the burst without losing or repeating a word.
- R4: During a claimed read, `ad_oe` is high and `ad_out` equals `loc_rdata` for the current `loc_addr`; otherwise `ad_out` is zero. During a write, `loc_wr` is high exactly in the cycles that end in a beat, with `loc_wdata` equal to `ad_in`.
- R5: A beat taken with `cyc_n` high is the last one. From the next cycle `claim_n` and `tgt_rdy_n` are high.
- R6: After the address edge, `tgt_rdy_n` stays high for `wait_cfg` cycles before the first beat. Every later beat of the same transaction has no wait state.
- R7: `loc_addr` starts at the decoded word offset (word address minus BASE/4) and rises by one after each beat.
- R8: `tgt_halt_n` is low while the current offset is DEPTH-1. A beat there ends the transaction, and `tgt_halt_n` stays low afterwards for as long as `cyc_n` is held low.
- R9: A transaction with an address outside the window, or with any command other than 4'h6/4'h7, is ignored. `claim_n` and `tgt_rdy_n` stay high and `loc_wr` stays low until the bus is idle.
- R10: After any transaction ends or is ignored, a new start is recognised only after an edge that sees `cyc_n` and `ini_rdy_n` both high.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_n | input | 1 | Active-low cycle signal from the initiator; released on the final beat |
| cmd | input | 4 | Command, valid on the address edge |
| ad_in | input | AD_W | Byte address on the address edge, write data afterwards |
| ini_rdy_n | input | 1 | Active-low initiator ready |
| wait_cfg | input | WAIT_W | Wait states before the first beat, sampled on the address edge |
| ad_out | output | AD_W | Read data towards the bus |
| ad_oe | output | 1 | Read data drive enable |
| claim_n | output | 1 | Active-low: the target owns the current transaction |
| tgt_rdy_n | output | 1 | Active-low target ready |
| tgt_halt_n | output | 1 | Active-low disconnect request |
| loc_addr | output | $clog2(DEPTH) | Word offset into the local memory |
| loc_wr | output | 1 | Local write strobe |
| loc_wdata | output | AD_W | Local write data |
| loc_rdata | input | AD_W | Local read data, combinational from `loc_addr` |

## Verification
`claim_n`, `tgt_rdy_n`, `ad_oe` and `loc_addr` come from registers, so each one changes one clock after the address edge or beat edge that causes it. The first `tgt_rdy_n` low comes `wait_cfg` cycles after that. `loc_wr`, `ad_out` and the post-disconnect halt also depend on the current inputs, so they are valid in the same cycle as those inputs. The bench drives inputs on the falling edge and compares every output 1 ns later against a behavioural model. The model steps on each rising edge with the inputs that edge sampled. Every output is therefore judged in the cycle it is due, with no skew.

// File: rtl/burst_tgt_pkg.sv
package burst_tgt_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,   // waiting for a start
    PH_XFER,   // claimed, moving words
    PH_SKIP,   // ignored transaction, wait for idle bus
    PH_DRAIN   // finished, wait for idle bus
  } phase_t;

  localparam logic [3:0] CMD_RD = 4'h6;
  localparam logic [3:0] CMD_WR = 4'h7;

  function automatic logic cmd_known(input logic [3:0] c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

  function automatic logic cmd_is_write(input logic [3:0] c);
    return c == CMD_WR;
  endfunction

endpackage

// File: rtl/burst_tgt_decode.sv
module burst_tgt_decode #(
  parameter int AD_W = 32,
  parameter int DEPTH = 16,
  parameter logic [AD_W-1:0] BASE = 'h1000,
  localparam int OFS_W = $clog2(DEPTH),
  localparam int WA_W = AD_W - 2
) (
  input  logic [WA_W-1:0]  word,
  output logic             hit,
  output logic [OFS_W-1:0] ofs
);

  localparam logic [WA_W-1:0] BASE_W  = BASE[AD_W-1:2];
  localparam logic [WA_W-1:0] DEPTH_W = WA_W'(DEPTH);

  logic [WA_W-1:0] diff;

  function automatic logic in_window(input logic [WA_W-1:0] w, input logic [WA_W-1:0] d);
    return (w >= BASE_W) && (d < DEPTH_W);
  endfunction

  always_comb begin
    diff = word - BASE_W;
    hit  = in_window(word, diff);
    ofs  = diff[OFS_W-1:0];
  end

endmodule

// File: rtl/burst_tgt_waitcnt.sv
module burst_tgt_waitcnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         run,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= load_val;
    else if (run && cnt != 0) cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R6: each running cycle with a non-zero count removes one wait state
  a_r6_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && run && !zero) |=> (cnt == $past(cnt) - W'(1)));

endmodule

// File: rtl/burst_tgt_ofs.sv
module burst_tgt_ofs #(
  parameter int DEPTH = 16,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFS_W-1:0] load_val,
  input  logic             adv,
  output logic [OFS_W-1:0] ofs,
  output logic             at_last
);

  localparam logic [OFS_W-1:0] LAST = OFS_W'(DEPTH - 1);

  function automatic logic [OFS_W-1:0] step(input logic [OFS_W-1:0] o);
    return (o == LAST) ? '0 : o + OFS_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)    ofs <= '0;
    else if (load) ofs <= load_val;
    else if (adv)  ofs <= step(ofs);
  end

  assign at_last = (ofs == LAST);

endmodule

// File: rtl/burst_tgt.sv
module burst_tgt
  import burst_tgt_pkg::*;
#(
  parameter int AD_W = 32,
  parameter int DEPTH = 16,
  parameter int WAIT_W = 3,
  parameter logic [AD_W-1:0] BASE = 'h1000,
  localparam int OFS_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cyc_n,
  input  logic [3:0]        cmd,
  input  logic [AD_W-1:0]   ad_in,
  input  logic              ini_rdy_n,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic [AD_W-1:0]   ad_out,
  output logic              ad_oe,
  output logic              claim_n,
  output logic              tgt_rdy_n,
  output logic              tgt_halt_n,
  output logic [OFS_W-1:0]  loc_addr,
  output logic              loc_wr,
  output logic [AD_W-1:0]   loc_wdata,
  input  logic [AD_W-1:0]   loc_rdata
);

  phase_t state, state_nx;
  logic   is_wr;

  // named internal events
  logic             start;
  logic             hit;
  logic             accept;
  logic             wzero;
  logic             tgt_ready;
  logic             beat;
  logic             final_beat;
  logic             at_last;
  logic             bus_idle;
  logic [OFS_W-1:0] dec_ofs;
  logic [OFS_W-1:0] ofs;

  burst_tgt_decode #(.AD_W(AD_W), .DEPTH(DEPTH), .BASE(BASE)) u_dec (
    .word (ad_in[AD_W-1:2]),
    .hit  (hit),
    .ofs  (dec_ofs)
  );

  burst_tgt_waitcnt #(.W(WAIT_W)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (wait_cfg),
    .run      (state == PH_XFER),
    .zero     (wzero)
  );

  burst_tgt_ofs #(.DEPTH(DEPTH)) u_ofs (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (dec_ofs),
    .adv      (beat),
    .ofs      (ofs),
    .at_last  (at_last)
  );

  always_comb begin
    start      = (state == PH_IDLE) && !cyc_n;
    accept     = start && hit && cmd_known(cmd);
    tgt_ready  = (state == PH_XFER) && wzero;
    beat       = tgt_ready && !ini_rdy_n;
    final_beat = beat && (cyc_n || at_last);
    bus_idle   = cyc_n && ini_rdy_n;
  end

  always_comb begin
    state_nx = state;
    unique case (state)
      PH_IDLE:  if (start) state_nx = accept ? PH_XFER : PH_SKIP;
      PH_XFER:  if (final_beat) state_nx = PH_DRAIN;
      PH_SKIP:  if (bus_idle) state_nx = PH_IDLE;
      PH_DRAIN: if (bus_idle) state_nx = PH_IDLE;
      default:  state_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PH_IDLE;
      is_wr <= 1'b0;
    end else begin
      state <= state_nx;
      if (accept) is_wr <= cmd_is_write(cmd);
    end
  end

  always_comb begin
    claim_n    = !(state == PH_XFER);
    tgt_rdy_n  = !tgt_ready;
    tgt_halt_n = !(((state == PH_XFER) && at_last) || ((state == PH_DRAIN) && !cyc_n));
    ad_oe      = (state == PH_XFER) && !is_wr;
    ad_out     = ad_oe ? loc_rdata : '0;
    loc_addr   = ofs;
    loc_wr     = beat && is_wr;
    loc_wdata  = ad_in;
  end

  // R1: outputs inactive right after reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (claim_n && tgt_rdy_n && tgt_halt_n && !ad_oe && !loc_wr));

  // R3: a local write only happens when both ready signals are low
  a_r3_both_ready: assert property (@(posedge clk) disable iff (!rst_n)
    loc_wr |-> (!ini_rdy_n && !tgt_rdy_n));

  // R4: read data is driven only inside a claimed transaction
  a_r4_oe_claimed: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !claim_n);

  // R5: a beat with the cycle signal released ends the transaction
  a_r5_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && cyc_n) |=> (claim_n && tgt_rdy_n));

  // R6: no wait state after the first beat
  a_r6_no_later_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !final_beat) |=> !tgt_rdy_n);

  // R7: offset steps by one after a non-final beat
  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !final_beat) |=> (loc_addr == $past(loc_addr) + OFS_W'(1)));

  // R8: a beat while halting ends the transaction
  a_r8_halt_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !tgt_halt_n) |=> (claim_n && tgt_rdy_n));

  // R9: a rejected start is never claimed
  a_r9_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !accept) |=> (claim_n && tgt_rdy_n && !loc_wr));

  // R10: no claim straight out of a non-idle bus after an ignored transaction
  a_r10_need_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PH_SKIP) && !bus_idle) |=> claim_n);

endmodule

// File: tb/tb_burst_tgt.sv
module tb_burst_tgt;

  localparam int CLK_NS = 10;
  localparam int AD_W   = 32;
  localparam int DEPTH  = 16;
  localparam int WAIT_W = 3;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam int OFS_W  = $clog2(DEPTH);
  localparam int BASE_W = 32'h1000 / 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cyc_n;
  logic [3:0]        cmd;
  logic [AD_W-1:0]   ad_in;
  logic              ini_rdy_n;
  logic [WAIT_W-1:0] wait_cfg;
  logic [AD_W-1:0]   ad_out;
  logic              ad_oe;
  logic              claim_n;
  logic              tgt_rdy_n;
  logic              tgt_halt_n;
  logic [OFS_W-1:0]  loc_addr;
  logic              loc_wr;
  logic [AD_W-1:0]   loc_wdata;
  logic [AD_W-1:0]   loc_rdata;

  burst_tgt #(.AD_W(AD_W), .DEPTH(DEPTH), .WAIT_W(WAIT_W), .BASE(BASE)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_n(cyc_n), .cmd(cmd), .ad_in(ad_in),
    .ini_rdy_n(ini_rdy_n), .wait_cfg(wait_cfg), .ad_out(ad_out), .ad_oe(ad_oe),
    .claim_n(claim_n), .tgt_rdy_n(tgt_rdy_n), .tgt_halt_n(tgt_halt_n),
    .loc_addr(loc_addr), .loc_wr(loc_wr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  // local memory seen by the design
  logic [AD_W-1:0] lmem [DEPTH];
  assign loc_rdata = lmem[loc_addr];
  always @(posedge clk) if (loc_wr) lmem[loc_addr] <= loc_wdata;

  // behavioural reference
  int              m_ph;    // 0 idle, 1 moving, 2 ignored, 3 finished
  int              m_ofs;
  int              m_wait;
  bit              m_wr;
  logic [AD_W-1:0] m_mem [DEPTH];

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [AD_W-1:0] act, input logic [AD_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare;
    bit moving, rdy, halt, oe, we;
    moving = (m_ph == 1);
    rdy    = moving && (m_wait == 0);
    halt   = (moving && m_ofs == DEPTH-1) || (m_ph == 3 && !cyc_n);
    oe     = moving && !m_wr;
    we     = rdy && !ini_rdy_n && m_wr;
    chk("R2 claim_n", 32'(claim_n), 32'(!moving));
    chk("R3/R6 tgt_rdy_n", 32'(tgt_rdy_n), 32'(!rdy));
    chk("R8 tgt_halt_n", 32'(tgt_halt_n), 32'(!halt));
    chk("R4 ad_oe", 32'(ad_oe), 32'(oe));
    chk("R4 ad_out", ad_out, oe ? m_mem[m_ofs] : '0);
    chk("R4/R9 loc_wr", 32'(loc_wr), 32'(we));
    if (we) chk("R4 loc_wdata", loc_wdata, ad_in);
    if (moving) chk("R7 loc_addr", 32'(loc_addr), 32'(m_ofs));
  endtask

  task automatic model_step;
    int word;
    if (!rst_n) begin
      m_ph = 0; m_ofs = 0; m_wait = 0; m_wr = 0;
      return;
    end
    case (m_ph)
      0: if (!cyc_n) begin
           word = int'(ad_in >> 2);
           if ((cmd == 4'h6 || cmd == 4'h7) && word >= BASE_W && word < BASE_W + DEPTH) begin
             m_ph = 1; m_ofs = word - BASE_W; m_wait = int'(wait_cfg); m_wr = (cmd == 4'h7);
           end else m_ph = 2;
         end
      1: if (m_wait > 0) m_wait--;
         else if (!ini_rdy_n) begin
           if (m_wr) m_mem[m_ofs] = ad_in;
           if (cyc_n || m_ofs == DEPTH-1) m_ph = 3;
           m_ofs = (m_ofs + 1) % DEPTH;
         end
      default: if (cyc_n && ini_rdy_n) m_ph = 0;
    endcase
  endtask

  task automatic tick;
    #1 compare();
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle_bus(input int n);
    cyc_n = 1; ini_rdy_n = 1; cmd = 4'h0; ad_in = '0;
    for (int i = 0; i < n; i++) tick();
  endtask

  // one burst; stall>0 withholds initiator ready every stall-th data cycle
  task automatic burst(input logic [3:0] c, input logic [31:0] a, input int n,
                       input int w, input int stall, output int beats, output int first_rdy);
    bit done, rdy, hit, halt;
    int k;
    wait_cfg = WAIT_W'(w); cyc_n = 0; cmd = c; ad_in = a; ini_rdy_n = 1;
    tick();
    beats = 0; done = 0; k = 0; first_rdy = -1; halt = 0;
    while (!done && k < 200) begin
      rdy = !(stall > 0 && (k % stall) == stall - 1);
      ini_rdy_n = !rdy;
      cyc_n = (rdy && beats == n - 1);
      ad_in = 32'hA500_0000 + a + 32'(beats);
      #1;
      if (!tgt_rdy_n && first_rdy < 0) first_rdy = k;
      hit  = rdy && !tgt_rdy_n;
      halt = !tgt_halt_n;
      tick();
      k++;
      if (hit) begin
        beats++;
        if (cyc_n || halt) done = 1;
      end
    end
    if (halt && !cyc_n) begin
      ini_rdy_n = 1;   // initiator slow to release the cycle signal
      #1 chk("R8 halt held while cyc_n low", 32'(tgt_halt_n), 32'h0);
      tick();
    end
    idle_bus(2);
  endtask

  int beats, frdy;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      lmem[i]  = 32'h1111_0000 * 32'(i) + 32'(i);
      m_mem[i] = 32'h1111_0000 * 32'(i) + 32'(i);
    end
    rst_n = 0; cyc_n = 1; cmd = 0; ad_in = 0; ini_rdy_n = 1; wait_cfg = 0;
    m_ph = 0; m_ofs = 0; m_wait = 0; m_wr = 0;
    @(negedge clk);
    tick(); tick();
    #1 chk("R1 claim_n in reset", 32'(claim_n), 32'h1);
    chk("R1 tgt_rdy_n in reset", 32'(tgt_rdy_n), 32'h1);
    chk("R1 loc_wr in reset", 32'(loc_wr), 32'h0);
    rst_n = 1;
    tick();

    // write 4 words from offset 2, no waits
    burst(4'h7, BASE + 32'h8, 4, 0, 0, beats, frdy);
    chk("R5 write beats", 32'(beats), 32'd4);
    chk("R6 no wait ready at once", 32'(frdy), 32'd0);

    // read them back with 3 wait states and initiator stalls
    burst(4'h6, BASE + 32'h8, 4, 3, 3, beats, frdy);
    chk("R3 read beats with stalls", 32'(beats), 32'd4);
    chk("R6 three wait states", 32'(frdy), 32'd3);

    // write crossing window end: halted after 3 beats
    burst(4'h7, BASE + 32'(4*(DEPTH-3)), 6, 1, 0, beats, frdy);
    chk("R8 halted write beats", 32'(beats), 32'd3);

    // read at last word, halt with first beat
    burst(4'h6, BASE + 32'(4*(DEPTH-1)), 4, 2, 2, beats, frdy);
    chk("R8 halted read beats", 32'(beats), 32'd1);

    // single-beat read
    burst(4'h6, BASE + 32'h10, 1, 0, 0, beats, frdy);
    chk("R5 single beat", 32'(beats), 32'd1);

    // miss: address past the window
    cyc_n = 0; cmd = 4'h7; ad_in = BASE + 32'(4*DEPTH); ini_rdy_n = 1; tick();
    ini_rdy_n = 0; ad_in = 32'hDEAD_0000;
    for (int i = 0; i < 4; i++) begin
      #1 chk("R9 miss not ready", 32'(tgt_rdy_n), 32'h1);
      tick();
    end
    // bus not idle yet: a new valid start must stay ignored
    cyc_n = 1; ini_rdy_n = 0; tick();
    cyc_n = 0; ini_rdy_n = 1; cmd = 4'h6; ad_in = BASE; tick();
    #1 chk("R10 no claim before idle", 32'(claim_n), 32'h1);
    idle_bus(2);

    // miss: unknown command inside the window
    cyc_n = 0; cmd = 4'h2; ad_in = BASE; ini_rdy_n = 1; tick();
    ini_rdy_n = 0;
    for (int i = 0; i < 3; i++) begin
      #1 chk("R9 bad cmd not claimed", 32'(claim_n), 32'h1);
      tick();
    end
    idle_bus(2);

    // below window
    burst(4'h6, BASE - 32'h4, 1, 0, 0, beats, frdy);
    chk("R9 below window no beats", 32'(beats), 32'd0);

    // read whole window to confirm memory contents, then back-to-back write
    burst(4'h6, BASE, DEPTH, 0, 4, beats, frdy);
    chk("R7 full window beats", 32'(beats), 32'(DEPTH));
    burst(4'h7, BASE + 32'h4, 2, 5, 0, beats, frdy);
    chk("R6 five wait states", 32'(frdy), 32'd5);
    burst(4'h6, BASE, 4, 0, 0, beats, frdy);
    chk("R4 final read beats", 32'(beats), 32'd4);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule